// File: doc/BRIEF.md
# Dead-Band and Trip-Zone Output Stage

This block sits between a raw two-channel PWM waveform and the gate pins of one half-bridge leg. It delays rising edges and falling edges of the source waveform by two independently set counts of the module clock, so that a single source can produce a complementary pair with a guard interval on both transitions. Either delay can be switched on alone, and a channel whose delay is off passes its raw input straight through.

Six active-low fault inputs are brought in through a two-flop synchroniser. Each fault input can be enabled as a latching fault, a self-clearing fault, or both. A latching fault holds its override until software pulses a clear input. A self-clearing fault drops its override at the first counter-zero strobe where no enabled fault remains. Each output has its own override action for each fault class: high-impedance, force high, force low, or leave alone. The latching class wins when both classes are active. A one-cycle interrupt pulse marks each entry into a fault state.

Top module: `deadband_trip_stage`

## Requirements
- R1: While reset is low and directly after it, both fault states are clear, trip_irq is low, both output enables are high, and with mode 2'b00 pwm_a equals raw_a and pwm_b equals raw_b.
- R2: When db_mode bit 0 is set, pwm_a rises once raw_a has stayed high through rise_dly rising clock edges. With rise_dly of 0 it rises at once. It falls in the same cycle as raw_a. A high pulse covering fewer than rise_dly edges produces no output pulse.
- R3: When db_mode bit 1 is set, pwm_b is the inverse of raw_a with its low-to-high transition held back by fall_dly clock edges. pwm_b falls in the same cycle that raw_a rises. A raw_a low pulse covering fewer than fall_dly edges produces no pwm_b pulse.
- R4: When db_mode bit 0 is clear, pwm_a equals raw_a. When db_mode bit 1 is clear, pwm_b equals raw_b.
- R5: With db_mode 2'b11 and no fault state active, pwm_a and pwm_b are never both high, for any pair of delays.
- R6: A fault input that is low at clock edge k sets the enabled fault state at edge k+2. The override is therefore visible after the third edge, whatever the PWM phase.
- R7: The latching state stays set until a cycle where ost_clr is high and no latch-enabled input is low at the synchroniser output. A fault present at that point wins over the clear.
- R8: The self-clearing state stays set until a clock edge where ctr_zero is high and no cbc-enabled input is low at the synchroniser output.
- R9: Action encoding is per output and per fault class. 2'b00 gives high-impedance: the enable is low and the pin value is low. 2'b01 forces the pin high and 2'b10 forces it low, both with the enable high. 2'b11 leaves the dead-band result in place.
- R10: When both fault states are set, each output uses its latching-class action.
- R11: A fault input whose enable bits are both clear has no effect on any output or on trip_irq.
- R12: trip_irq is high for exactly the cycle after the edge at which either fault state goes from clear to set. It stays low while a state only remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw PWM channel A, dead-band source |
| raw_b | input | 1 | Raw PWM channel B |
| db_mode | input | 2 | Bit 0 enables rising delay on A, bit 1 builds B from delayed inverted A |
| rise_dly | input | 10 | Rising-edge delay in clocks |
| fall_dly | input | 10 | Falling-edge delay in clocks |
| trip_n | input | 6 | Active-low fault inputs, asynchronous |
| ost_en | input | 6 | Per-input latching fault enable |
| cbc_en | input | 6 | Per-input self-clearing fault enable |
| ost_clr | input | 1 | Clears the latching fault state |
| ctr_zero | input | 1 | Counter-zero strobe from the time base |
| ost_act_a | input | 2 | Action on output A for a latching fault |
| ost_act_b | input | 2 | Action on output B for a latching fault |
| cbc_act_a | input | 2 | Action on output A for a self-clearing fault |
| cbc_act_b | input | 2 | Action on output B for a self-clearing fault |
| pwm_a | output | 1 | Final gate signal A |
| pwm_b | output | 1 | Final gate signal B |
| oe_a | output | 1 | Drive enable for A, low means high-impedance |
| oe_b | output | 1 | Drive enable for B, low means high-impedance |
| trip_irq | output | 1 | Fault-entry interrupt pulse |

## Verification
The latency property treats ost_en as static configuration. The bench sets all enables and delays only while no fault is pending in the synchroniser, and holds them steady through every fault episode. Fault inputs change only between clock edges, so the synchroniser sees each level cleanly. Mode and delay changes happen mid-run only while fault states are clear, so the no-overlap property covers every complementary segment.

// File: rtl/deadband_trip_stage.sv
module deadband_trip_stage #(
  parameter int DLY_W  = 10,
  parameter int N_TRIP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_a,
  input  logic              raw_b,
  input  logic [1:0]        db_mode,
  input  logic [DLY_W-1:0]  rise_dly,
  input  logic [DLY_W-1:0]  fall_dly,
  input  logic [N_TRIP-1:0] trip_n,
  input  logic [N_TRIP-1:0] ost_en,
  input  logic [N_TRIP-1:0] cbc_en,
  input  logic              ost_clr,
  input  logic              ctr_zero,
  input  logic [1:0]        ost_act_a,
  input  logic [1:0]        ost_act_b,
  input  logic [1:0]        cbc_act_a,
  input  logic [1:0]        cbc_act_b,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              oe_a,
  output logic              oe_b,
  output logic              trip_irq
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  logic [DLY_W-1:0]  hi_cnt, lo_cnt;
  logic [N_TRIP-1:0] sync1, sync2;
  logic              ost_q, cbc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= CNT_MAX;
    end else if (raw_a) begin
      hi_cnt <= (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == CNT_MAX) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  wire rise_held = raw_a && (hi_cnt >= rise_dly);
  wire fall_held = raw_a || (lo_cnt < fall_dly);
  wire core_a    = db_mode[0] ? rise_held  : raw_a;
  wire core_b    = db_mode[1] ? !fall_held : raw_b;

  wire ost_hit = |(ost_en & ~sync2);
  wire cbc_hit = |(cbc_en & ~sync2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '1;
      sync2    <= '1;
      ost_q    <= 1'b0;
      cbc_q    <= 1'b0;
      trip_irq <= 1'b0;
    end else begin
      sync1    <= trip_n;
      sync2    <= sync1;
      ost_q    <= ost_hit | (ost_q & ~ost_clr);
      cbc_q    <= cbc_hit | (cbc_q & ~ctr_zero);
      trip_irq <= (ost_hit & ~ost_q) | (cbc_hit & ~cbc_q);
    end
  end

  function automatic logic [1:0] apply_act(input logic [1:0] act, input logic v);
    case (act)
      2'b00:   return 2'b00;
      2'b01:   return 2'b11;
      2'b10:   return 2'b10;
      default: return {1'b1, v};
    endcase
  endfunction

  wire [1:0] sel_a = ost_q ? ost_act_a : (cbc_q ? cbc_act_a : 2'b11);
  wire [1:0] sel_b = ost_q ? ost_act_b : (cbc_q ? cbc_act_b : 2'b11);

  assign {oe_a, pwm_a} = apply_act(sel_a, core_a);
  assign {oe_b, pwm_b} = apply_act(sel_b, core_b);
endmodule

// File: rtl/deadband_trip_stage_chk.sv
module deadband_trip_stage_chk #(
  parameter int N_TRIP = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        db_mode,
  input logic [N_TRIP-1:0] trip_n,
  input logic [N_TRIP-1:0] ost_en,
  input logic              ost_clr,
  input logic              ctr_zero,
  input logic [1:0]        ost_act_a,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic              oe_a,
  input logic              oe_b,
  input logic              trip_irq,
  input logic              ost_q,
  input logic              cbc_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R9
  hiz_a_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_a |-> !pwm_a);
  // R9
  hiz_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_b |-> !pwm_b);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_mode == 2'b11 && !ost_q && !cbc_q) |-> !(pwm_a && pwm_b));
  // R7
  ost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_q && !ost_clr) |=> ost_q);
  // R8
  cbc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_q && !ctr_zero) |=> cbc_q);
  // R12
  irq_with_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_irq |-> (ost_q || cbc_q));
  // R6
  trip_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(|(ost_en & ~trip_n), 2)) |=> ost_q);
  // R10
  ost_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_q && cbc_q && ost_act_a == 2'b01) |-> (oe_a && pwm_a));
endmodule

bind deadband_trip_stage deadband_trip_stage_chk #(.N_TRIP(N_TRIP)) chk_i (
  .clk(clk), .rst_n(rst_n), .db_mode(db_mode), .trip_n(trip_n), .ost_en(ost_en),
  .ost_clr(ost_clr), .ctr_zero(ctr_zero), .ost_act_a(ost_act_a),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b), .trip_irq(trip_irq),
  .ost_q(ost_q), .cbc_q(cbc_q)
);

// File: tb/deadband_trip_stage_tb_top.sv
module deadband_trip_stage_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, raw_a, raw_b, ost_clr, ctr_zero;
  logic [1:0] db_mode, ost_act_a, ost_act_b, cbc_act_a, cbc_act_b;
  logic [9:0] rise_dly, fall_dly;
  logic [5:0] trip_n, ost_en, cbc_en;
  logic       pwm_a, pwm_b, oe_a, oe_b, trip_irq;

  deadband_trip_stage dut_i (
    .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b), .db_mode(db_mode),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .trip_n(trip_n), .ost_en(ost_en),
    .cbc_en(cbc_en), .ost_clr(ost_clr), .ctr_zero(ctr_zero),
    .ost_act_a(ost_act_a), .ost_act_b(ost_act_b), .cbc_act_a(cbc_act_a),
    .cbc_act_b(cbc_act_b), .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b),
    .trip_irq(trip_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  int run_hi, run_lo;
  logic [5:0] seen1, seen2;
  bit m_ost, m_cbc, m_irq;

  task automatic model_edge();
    bit ho, hc;
    if (!rst_n) begin
      run_hi = 0; run_lo = 1 << 20; seen1 = '1; seen2 = '1;
      m_ost = 0; m_cbc = 0; m_irq = 0;
    end else begin
      ho = |(ost_en & ~seen2);
      hc = |(cbc_en & ~seen2);
      m_irq = (ho && !m_ost) || (hc && !m_cbc);
      m_ost = ho || (m_ost && !ost_clr);
      m_cbc = hc || (m_cbc && !ctr_zero);
      seen2 = seen1;
      seen1 = trip_n;
      if (raw_a) begin run_hi++; run_lo = 0; end
      else begin run_lo++; run_hi = 0; end
    end
  endtask

  function automatic void act_map(input logic [1:0] act, input bit v, output bit oe, output bit o);
    case (act)
      2'b00: begin oe = 0; o = 0; end
      2'b01: begin oe = 1; o = 1; end
      2'b10: begin oe = 1; o = 0; end
      default: begin oe = 1; o = v; end
    endcase
  endfunction

  task automatic chk(input string what, input logic act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit ca, cb, ea, eb, eoa, eob;
    logic [1:0] sa, sb;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ca = db_mode[0] ? (raw_a && run_hi >= int'(rise_dly)) : raw_a;
    cb = db_mode[1] ? !(raw_a || run_lo < int'(fall_dly)) : raw_b;
    sa = m_ost ? ost_act_a : (m_cbc ? cbc_act_a : 2'b11);
    sb = m_ost ? ost_act_b : (m_cbc ? cbc_act_b : 2'b11);
    act_map(sa, ca, eoa, ea);
    act_map(sb, cb, eob, eb);
    chk("pwm_a", pwm_a, ea);
    chk("pwm_b", pwm_b, eb);
    chk("oe_a", oe_a, eoa);
    chk("oe_b", oe_b, eob);
    chk("trip_irq(R12)", trip_irq, m_irq);
    if (req == "R5") chk("overlap", pwm_a & pwm_b, 1'b0);
  endtask

  task automatic hold(input bit v, input int n);
    raw_a = v;
    repeat (n) step();
  endtask

  initial begin
    rst_n = 0; raw_a = 0; raw_b = 0; ost_clr = 0; ctr_zero = 0;
    db_mode = 2'b00; rise_dly = 0; fall_dly = 0;
    trip_n = '1; ost_en = '0; cbc_en = '0;
    ost_act_a = 2'b11; ost_act_b = 2'b11; cbc_act_a = 2'b11; cbc_act_b = 2'b11;
    req = "R1";
    repeat (3) step();
    rst_n = 1; raw_a = 1; raw_b = 0;
    repeat (4) step();

    req = "R4";
    for (int i = 0; i < 30; i++) begin
      raw_a = 1'($urandom); raw_b = 1'($urandom); step();
    end
    db_mode = 2'b01; rise_dly = 2;
    for (int i = 0; i < 20; i++) begin
      raw_a = 1'($urandom); raw_b = 1'($urandom); step();
    end

    req = "R2";
    db_mode = 2'b01; rise_dly = 5; hold(0, 6);
    hold(1, 8); hold(0, 6); hold(1, 3); hold(0, 6); hold(1, 5); hold(0, 3);
    rise_dly = 0; hold(1, 2); hold(0, 2);

    req = "R3";
    db_mode = 2'b10; fall_dly = 4; hold(1, 3);
    hold(0, 7); hold(1, 3); hold(0, 2); hold(1, 5); hold(0, 8); hold(1, 1);
    fall_dly = 0; hold(0, 2); hold(1, 2);

    req = "R5";
    db_mode = 2'b11; rise_dly = 3; fall_dly = 2;
    for (int i = 0; i < 80; i++) begin raw_a = 1'($urandom); step(); end
    rise_dly = 0; fall_dly = 0;
    for (int i = 0; i < 20; i++) begin raw_a = 1'($urandom); step(); end

    req = "R6";
    rise_dly = 2; fall_dly = 2;
    ost_en = 6'b000001; ost_act_a = 2'b10; ost_act_b = 2'b00;
    raw_a = 1; trip_n[0] = 0; step();
    trip_n[0] = 1;
    for (int i = 0; i < 8; i++) begin raw_a = 1'($urandom); step(); end

    req = "R7";
    for (int i = 0; i < 5; i++) begin raw_a = 1'($urandom); step(); end
    ost_clr = 1; step(); ost_clr = 0;
    for (int i = 0; i < 5; i++) begin raw_a = 1'($urandom); step(); end
    trip_n[0] = 0; repeat (4) step();
    ost_clr = 1; repeat (4) step();
    trip_n[0] = 1; repeat (4) step();
    ost_clr = 0; repeat (3) step();

    req = "R8";
    ost_en = '0; cbc_en = 6'b001000; cbc_act_a = 2'b01; cbc_act_b = 2'b10;
    for (int i = 0; i < 40; i++) begin
      ctr_zero = (i % 6 == 0);
      trip_n[3] = !(i >= 3 && i < 12);
      raw_a = 1'($urandom);
      step();
    end
    ctr_zero = 0;

    req = "R9";
    for (int k = 0; k < 4; k++) begin
      cbc_act_a = 2'(k); cbc_act_b = 2'(3 - k);
      trip_n[3] = 0; step(); trip_n[3] = 1;
      for (int i = 0; i < 6; i++) begin raw_a = 1'($urandom); step(); end
      ctr_zero = 1; step(); ctr_zero = 0; step();
    end

    req = "R10";
    ost_en = 6'b000001; cbc_en = 6'b001000;
    ost_act_a = 2'b01; ost_act_b = 2'b10; cbc_act_a = 2'b10; cbc_act_b = 2'b01;
    trip_n[3] = 0; repeat (4) step();
    trip_n[0] = 0; step(); trip_n[0] = 1;
    for (int i = 0; i < 5; i++) begin raw_a = 1'($urandom); step(); end
    ost_clr = 1; step(); ost_clr = 0;
    repeat (3) step();
    trip_n[3] = 1; repeat (3) step();
    ctr_zero = 1; step(); ctr_zero = 0; repeat (2) step();

    req = "R11";
    ost_en = 6'b000001; cbc_en = 6'b001000;
    ost_act_a = 2'b00; ost_act_b = 2'b00;
    trip_n[5] = 0; trip_n[2] = 0;
    for (int i = 0; i < 12; i++) begin raw_a = 1'($urandom); step(); end
    trip_n = '1; repeat (3) step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule